// File: doc/BRIEF.md
# Erased Chunk Zero-Bit Counter

This block watches one error-correction chunk as it streams past, byte by byte. A chunk is a 512-byte payload followed by 13 stored check bytes. When the correction engine reports a chunk as beyond repair, a freshly erased page is the likely cause. An erased page reads as all ones, but its stored check bytes do not match what the engine computes for all-ones data. The block counts the bits that read as zero in each of the two regions of the chunk and decides whether the chunk is an erased page with only a few flipped bits.

Each byte arrives with a valid strobe, a tag that marks it as payload or check byte, and a last marker on the final byte of the chunk. Each region has its own tally, and each tally stops rising once it passes the limit. One cycle after the last byte is accepted, the block presents three things: the payload zero count, which is the corrected-bit count, a saturated total, and a verdict. The verdict is erased, erased with the payload to be forced to 0xFF, or uncorrectable. The block does not rewrite the buffer. It only raises the force-to-ones flag.

Top module: `ezc_erased_chunk_check`

## Requirements
- R1: Every 0 bit in an accepted byte adds one to the tally of that byte's region, so a byte adds the popcount of its inverse (0x00 adds 8, 0xFF adds 0).
- R2: `in_is_ecc`=0 sends the byte to the payload tally. `in_is_ecc`=1 sends it to the check-byte tally. Only the payload tally is reported on `data_zeros`.
- R3: Each region tally saturates at LIMIT+1 (9). `total_zeros` is min(payload+check, 9).
- R4: With `res_valid`=1, `chunk_erased`=1 exactly when the unsaturated payload+check zero count is at most LIMIT (8).
- R5: With `res_valid`=1, `fill_ones`=1 exactly when the chunk is erased and the payload zero count is nonzero.
- R6: With `res_valid`=1, `uncorrectable`=1 exactly when payload+check exceeds 8. It is never high together with `chunk_erased`.
- R7: `res_valid` rises in the cycle after a byte with `in_last`=1 is accepted and stays low during a chunk. The results stay unchanged until the next byte is accepted.
- R8: The first byte accepted after reset or after a last byte starts a new chunk, and both tallies restart from that byte alone.
- R9: After reset, `res_valid`, all flags and both counts are 0.
- R10: A byte presented with `in_valid`=0 changes no tally and no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte on `in_byte` is accepted this cycle |
| in_byte | input | BW | Byte read from the flash |
| in_is_ecc | input | 1 | 1: check byte, 0: payload byte |
| in_last | input | 1 | Final byte of the chunk |
| res_valid | output | 1 | Results below are for the finished chunk |
| data_zeros | output | CW | Payload zero count, saturated at 9 (corrected-bit count) |
| total_zeros | output | CW | Payload plus check zeros, saturated at 9 |
| chunk_erased | output | 1 | Chunk treated as erased |
| fill_ones | output | 1 | Erased with flips: payload must become all 0xFF |
| uncorrectable | output | 1 | Too many zeros: chunk failed |

## Verification
A tally that counts the wrong bits, misses the region tag or leaks across chunks shows up in `data_zeros` or `total_zeros` at the result cycle of that very chunk. A wrong saturation point or a wrong threshold flips the verdict flags only when the zero counts sit next to 8 or 9. For that reason the bench sweeps every pair of payload and check zero counts from 0 to 10 and compares each result with the arithmetic. A wrong valid or hold sequence shows up one cycle early or late on `res_valid`, or as results that drift during idle gaps.

// File: rtl/ezc_pkg.sv
package ezc_pkg;

  // number of 0 bits in the low w bits of v
  function automatic int unsigned zero_bits(input logic [63:0] v, input int unsigned w);
    int unsigned n;
    n = 0;
    for (int unsigned i = 0; i < 64; i++) begin
      if (i < w && !v[i]) n++;
    end
    return n;
  endfunction

  // a + b clipped at cap
  function automatic int unsigned sat_sum(input int unsigned a, input int unsigned b,
                                          input int unsigned cap);
    return (a + b > cap) ? cap : a + b;
  endfunction

endpackage

// File: rtl/ezc_tally.sv
module ezc_tally #(
  parameter int unsigned BW  = 8,
  parameter int unsigned CAP = 9,
  parameter int unsigned CW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          fresh,
  input  logic          mine,
  input  logic [BW-1:0] byte_in,
  output logic [CW-1:0] tally
);
  import ezc_pkg::*;

  logic [CW-1:0] step_base;
  int unsigned   zb;

  always_comb begin
    zb        = zero_bits(64'(byte_in), BW);
    step_base = fresh ? '0 : tally;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tally <= '0;
    end else if (acc) begin
      if (mine) tally <= CW'(sat_sum(int'(step_base), zb, CAP));
      else      tally <= step_base;
    end
  end

  // R3
  tally_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tally) <= CAP);

  // R10
  tally_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(tally));

  // R1
  tally_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !fresh |=> tally >= $past(tally));

endmodule

// File: rtl/ezc_verdict.sv
module ezc_verdict #(
  parameter int unsigned LIMIT = 8,
  parameter int unsigned CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic [CW-1:0] d_cnt,
  input  logic [CW-1:0] e_cnt,
  output logic [CW-1:0] total,
  output logic          erased,
  output logic          fill,
  output logic          fail
);
  import ezc_pkg::*;

  localparam int unsigned CAP = LIMIT + 1;

  logic fits;

  always_comb begin
    total  = CW'(sat_sum(int'(d_cnt), int'(e_cnt), CAP));
    fits   = int'(total) <= LIMIT;
    erased = done && fits;
    fill   = done && fits && (d_cnt != '0);
    fail   = done && !fits;
  end

  // R6
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(erased && fail));

  // R4
  erased_small_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erased |-> (int'(d_cnt) + int'(e_cnt) <= LIMIT));

  // R3
  total_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    total >= d_cnt && total >= e_cnt);

endmodule

// File: rtl/ezc_erased_chunk_check.sv
module ezc_erased_chunk_check #(
  parameter int unsigned BW    = 8,
  parameter int unsigned LIMIT = 8,
  localparam int unsigned CAP  = LIMIT + 1,
  localparam int unsigned CW   = $clog2(CAP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [BW-1:0] in_byte,
  input  logic          in_is_ecc,
  input  logic          in_last,
  output logic          res_valid,
  output logic [CW-1:0] data_zeros,
  output logic [CW-1:0] total_zeros,
  output logic          chunk_erased,
  output logic          fill_ones,
  output logic          uncorrectable
);

  localparam int unsigned NREG = 2; // 0: payload, 1: check bytes

  logic          fresh_q;
  logic          done_q;
  logic          accept;
  logic [CW-1:0] tallies [NREG];

  assign accept = in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh_q <= 1'b1;
      done_q  <= 1'b0;
    end else if (accept) begin
      fresh_q <= in_last;
      done_q  <= in_last;
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_region
    ezc_tally #(.BW(BW), .CAP(CAP), .CW(CW)) i_tally (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc     (accept),
      .fresh   (fresh_q),
      .mine    (in_is_ecc == r[0]),
      .byte_in (in_byte),
      .tally   (tallies[r])
    );
  end

  ezc_verdict #(.LIMIT(LIMIT), .CW(CW)) i_verdict (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (done_q),
    .d_cnt  (tallies[0]),
    .e_cnt  (tallies[1]),
    .total  (total_zeros),
    .erased (chunk_erased),
    .fill   (fill_ones),
    .fail   (uncorrectable)
  );

  assign res_valid  = done_q;
  assign data_zeros = tallies[0];

  // R7
  res_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(in_valid && in_last));

  // R7
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !in_valid |=> res_valid && $stable(data_zeros) && $stable(total_zeros));

  // R8
  fresh_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && in_valid && !in_last |=> !res_valid);

endmodule

// File: tb/test_ezc_erased_chunk_check.sv
module test_ezc_erased_chunk_check;

  localparam int PERIOD  = 10;
  localparam int NDATA   = 512;
  localparam int NECC    = 13;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       in_is_ecc = 1'b0;
  logic       in_last = 1'b0;
  logic       res_valid;
  logic [3:0] data_zeros;
  logic [3:0] total_zeros;
  logic       chunk_erased;
  logic       fill_ones;
  logic       uncorrectable;

  int total = 0;
  int bad   = 0;

  always #(PERIOD/2) clk = ~clk;

  ezc_erased_chunk_check i_ezc_erased_chunk_check (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_is_ecc(in_is_ecc), .in_last(in_last), .res_valid(res_valid),
    .data_zeros(data_zeros), .total_zeros(total_zeros),
    .chunk_erased(chunk_erased), .fill_ones(fill_ones),
    .uncorrectable(uncorrectable)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input logic ecc, input logic last, input bit gap);
    if (gap) begin
      @(negedge clk);
      in_valid = 1'b0; in_byte = 8'h00; in_is_ecc = ~ecc; in_last = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b1; in_byte = b; in_is_ecc = ecc; in_last = last;
  endtask

  // one zero bit per chosen byte; nd zeros in payload, ne in check bytes
  task automatic run_chunk(input int nd, input int ne, input bit gaps);
    for (int i = 0; i < NDATA; i++) begin
      logic [7:0] b;
      b = 8'hFF;
      for (int k = 0; k < nd; k++)
        if ((k * 37) % NDATA == i) b[k % 8] = 1'b0;
      put(b, 1'b0, 1'b0, gaps && (i % 97 == 5));
    end
    chk("R7 busy", int'(res_valid), 0);
    for (int i = 0; i < NECC; i++) begin
      logic [7:0] b;
      b = 8'hFF;
      for (int k = 0; k < ne; k++)
        if ((k * 5) % NECC == i) b[(k + 3) % 8] = 1'b0;
      put(b, 1'b1, i == NECC - 1, gaps && (i == 4));
    end
    @(negedge clk);
    in_valid = 1'b0; in_byte = 8'h00; in_last = 1'b0;
  endtask

  task automatic check_result(input int nd, input int ne);
    int d, t;
    bit er;
    d  = (nd > 9) ? 9 : nd;
    t  = (nd + ne > 9) ? 9 : nd + ne;
    er = (nd + ne) <= 8;
    chk("R7 res_valid", int'(res_valid), 1);
    chk("R1 R2 data_zeros", int'(data_zeros), d);
    chk("R3 total_zeros", int'(total_zeros), t);
    chk("R4 erased", int'(chunk_erased), int'(er));
    chk("R5 fill_ones", int'(fill_ones), int'(er && nd > 0));
    chk("R6 uncorrectable", int'(uncorrectable), int'(!er));
  endtask

  initial begin
    #(PERIOD * 190000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 res_valid", int'(res_valid), 0);
    chk("R9 data_zeros", int'(data_zeros), 0);
    chk("R9 total_zeros", int'(total_zeros), 0);
    chk("R9 flags", int'(chunk_erased) + int'(fill_ones) + int'(uncorrectable), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 heavy saturation: every byte 0x00
    for (int i = 0; i < NDATA + NECC; i++)
      put(8'h00, i >= NDATA, i == NDATA + NECC - 1, 1'b0);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    chk("R3 sat data", int'(data_zeros), 9);
    chk("R3 sat total", int'(total_zeros), 9);
    chk("R6 sat fail", int'(uncorrectable), 1);

    // R10 idle cycles with junk bytes leave results alone (R7 hold)
    for (int g = 0; g < 4; g++) begin
      @(negedge clk);
      in_byte = 8'h0F; in_is_ecc = g[0]; in_last = g[1];
    end
    @(negedge clk);
    chk("R10 idle hold data", int'(data_zeros), 9);
    chk("R7 hold valid", int'(res_valid), 1);

    // R8: clean chunk right after a saturated one must read zero
    // full sweep, R1..R6
    for (int nd = 0; nd <= 10; nd++)
      for (int ne = 0; ne <= 10; ne++) begin
        run_chunk(nd, ne, ((nd + ne) % 3) == 0);
        check_result(nd, ne);
        if (nd == 0 && ne == 0) chk("R8 cleared", int'(total_zeros), 0);
      end

    // R2: check bytes only, heavy zeros in one byte
    for (int i = 0; i < NDATA + NECC; i++)
      put((i == NDATA + 2) ? 8'h00 : 8'hFF, i >= NDATA, i == NDATA + NECC - 1, 1'b0);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    chk("R2 ecc only data", int'(data_zeros), 0);
    chk("R2 ecc only total", int'(total_zeros), 8);
    chk("R5 no fill", int'(fill_ones), 0);
    chk("R4 erased at limit", int'(chunk_erased), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule